// File: doc/BRIEF.md
# Sync-Framed Serial Receiver

This block is a receive-only serial front end for an external sampling converter. It generates a free-running serial clock and shifts in the converter's data line one bit per clock. It splits the incoming bit stream into 8-bit words, counting from the moment the clock is enabled. It checks each word against the fixed synchronization value 0xA5.

While the block is hunting, a word that does not match only becomes the header candidate. When the sync value arrives, the candidate is copied into a header register and a frame starts. The sync word and every frame word after it are handed to software through a data register that has a ready flag. The frame ends after its two trailing checksum words, which are delivered unchecked like any other word. The block then goes back to hunting.

A 2-bit oversampling-rate input selects the frame length. The block latches this input at the moment the sync word is found.

Top module: `syncframe_rx`

## Requirements
- R1: While `enable` is high, `sclk_o` toggles every `HALF_DIV` system clock cycles, so one full serial clock period is 2*`HALF_DIV` cycles. While `enable` is low, `sclk_o` is held low.
- R2: Data is taken from `sdi` at each low-to-high transition of `sclk_o` (clock mode 0). The first bit of each 8-bit word is its most significant bit.
- R3: Words are aligned to the first rising edge of `sclk_o` after enable. A word equal to 0xA5 that is received while hunting starts a frame, and that 0xA5 is the first word delivered to `rx_data`.
- R4: At the moment a frame starts, `header` takes the word that was received just before the sync word. It changes at no other time except reset.
- R5: After the sync word, a frame holds 6*(`osr_sel`+1) payload words followed by 2 checksum words. All of them are delivered in order, including any 0xA5 values inside the frame. The `osr_sel` codes 0, 1, 2 and 3 therefore deliver 9, 15, 21 and 27 words, counting the sync word.
- R6: `osr_sel` is sampled only when the sync word is found. A change to it during a frame does not alter that frame's length.
- R7: Words received outside a frame are never delivered. After the last checksum word the block hunts again, and the next 0xA5 starts a new frame.
- R8: `rx_ready` is set when a word is written to `rx_data`. A one-cycle `rd_strobe` while `rx_ready` is high clears `rx_ready` when no new word arrives in that cycle.
- R9: If a word is delivered while `rx_ready` is still high and `rd_strobe` is low, the word overwrites `rx_data` and `overrun` is set. `overrun` then stays high until reset.
- R10: While the synchronous reset `rst` is high, `sclk_o`, `rx_ready`, `overrun`, `in_frame`, `rx_data` and `header` are all forced to zero, and the block returns to hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the serial clock while high |
| osr_sel | input | 2 | Oversampling-rate code that selects the frame length |
| sdi | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| rd_strobe | input | 1 | Read pulse that consumes the data register |
| rx_data | output | 8 | Most recently delivered frame word |
| rx_ready | output | 1 | A new word is waiting in `rx_data` |
| overrun | output | 1 | Sticky flag: an unread word was overwritten |
| header | output | 8 | Word received just before the most recent sync |
| in_frame | output | 1 | High while the words of a frame are being delivered |

## Verification
The main stream pattern is sent once for every oversampling code. It contains noise words, a header, a sync, a frame that has 0xA5 embedded in its payload, a stray word, a second header, and a second frame. This pattern shows whether the frame length follows the code and whether an embedded sync value is wrongly taken as a new frame start. It also shows whether the words between frames are kept out of the data register and whether the header tracks the word before each sync.

Three more patterns cover the remaining cases. One changes the rate code in the middle of a frame, to separate latching at sync from continuous use of the input. One leaves the register unread, to expose the overwrite and sticky-overrun behaviour. One measures the clock period and checks the idle level.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int WORD_W       = 8;
  localparam int PAYLOAD_STEP = 6;
  localparam int CHECK_WORDS  = 2;
  localparam int OSR_W        = 2;
  localparam int TAIL_MAX     = PAYLOAD_STEP * (1 << OSR_W) + CHECK_WORDS;
  localparam int TAIL_W       = $clog2(TAIL_MAX + 1);
  localparam logic [WORD_W-1:0] SYNC_WORD = 8'hA5;

  typedef enum logic {ST_HUNT, ST_FRAME} sfr_state_e;

  // words still to come after the sync word: payload plus checksum
  function automatic logic [TAIL_W-1:0] tail_len(input logic [OSR_W-1:0] osr);
    return TAIL_W'(PAYLOAD_STEP * (int'(osr) + 1) + CHECK_WORDS);
  endfunction
endpackage

// File: rtl/sfr_clkgen.sv
module sfr_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic sclk,
  output logic rise_evt
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = enable && (cnt == CNT_LAST);
  assign rise_evt = wrap && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rise_evt,
  input  logic              sdi,
  output logic              byte_valid,
  output logic [WORD_W-1:0] byte_q
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0]  bitcnt;
  logic [WORD_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt     <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
      byte_q     <= '0;
    end else if (!enable) begin
      bitcnt     <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (rise_evt) begin
        sh <= {sh[WORD_W-3:0], sdi};
        if (bitcnt == BIT_LAST) begin
          byte_q     <= {sh, sdi};
          byte_valid <= 1'b1;
          bitcnt     <= '0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfr_framer.sv
module sfr_framer
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [WORD_W-1:0] byte_q,
  input  logic [OSR_W-1:0]  osr_sel,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              overrun,
  output logic [WORD_W-1:0] header,
  output logic              in_frame,
  output logic              deliver,
  output logic              sync_hit
);
  sfr_state_e        state;
  logic [TAIL_W-1:0] remain;
  logic [WORD_W-1:0] prev;

  assign in_frame = (state == ST_FRAME);
  assign sync_hit = byte_valid && !in_frame && (byte_q == SYNC_WORD);
  assign deliver  = sync_hit || (byte_valid && in_frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      remain   <= '0;
      prev     <= '0;
      header   <= '0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (byte_valid) prev <= byte_q;

      if (sync_hit) begin
        header <= prev;
        remain <= tail_len(osr_sel);
        state  <= ST_FRAME;
      end else if (byte_valid && in_frame) begin
        if (remain == TAIL_W'(1)) state <= ST_HUNT;
        remain <= remain - 1'b1;
      end

      if (deliver) begin
        rx_data  <= byte_q;
        rx_ready <= 1'b1;
        if (rx_ready && !rd_strobe) overrun <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/syncframe_rx.sv
module syncframe_rx
  import sfr_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [OSR_W-1:0]  osr_sel,
  input  logic              sdi,
  output logic              sclk_o,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              overrun,
  output logic [WORD_W-1:0] header,
  output logic              in_frame
);
  logic              rise_evt;
  logic              byte_valid;
  logic [WORD_W-1:0] byte_q;
  logic              deliver;
  logic              sync_hit;

  sfr_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .enable(enable), .sclk(sclk_o), .rise_evt(rise_evt)
  );

  sfr_shifter u_shift (
    .clk(clk), .rst(rst), .enable(enable), .rise_evt(rise_evt), .sdi(sdi),
    .byte_valid(byte_valid), .byte_q(byte_q)
  );

  sfr_framer u_frame (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_q(byte_q),
    .osr_sel(osr_sel), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_ready(rx_ready), .overrun(overrun), .header(header),
    .in_frame(in_frame), .deliver(deliver), .sync_hit(sync_hit)
  );
endmodule

// File: rtl/syncframe_rx_chk.sv
module syncframe_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       sclk_o,
  input logic       rd_strobe,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       overrun,
  input logic [7:0] header,
  input logic       in_frame,
  input logic       rise_evt,
  input logic       byte_valid,
  input logic [7:0] byte_q,
  input logic       deliver,
  input logic       sync_hit
);
  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sclk_o);
  // R2
  sample_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> sclk_o);
  // R4
  header_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(header) |-> $past(sync_hit));
  // R7
  hunt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !in_frame && byte_q != 8'hA5) |=> $stable(rx_data));
  // R8
  ready_from_delivery_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(deliver));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_ready && deliver && !rd_strobe));
  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!rx_ready && !overrun && !sclk_o && !in_frame));
endmodule

bind syncframe_rx syncframe_rx_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .sclk_o(sclk_o),
  .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
  .overrun(overrun), .header(header), .in_frame(in_frame),
  .rise_evt(rise_evt), .byte_valid(byte_valid), .byte_q(byte_q),
  .deliver(deliver), .sync_hit(sync_hit)
);

// File: tb/syncframe_rx_test.sv
module syncframe_rx_test;
  localparam int HD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [1:0] osr_sel = 2'd0;
  logic       sdi;
  logic       sclk_o;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       overrun;
  logic [7:0] header;
  logic       in_frame;

  syncframe_rx #(.HALF_DIV(HD)) uut (
    .clk(clk), .rst(rst), .enable(enable), .osr_sel(osr_sel), .sdi(sdi),
    .sclk_o(sclk_o), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_ready(rx_ready), .overrun(overrun), .header(header), .in_frame(in_frame)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial source: bit index counted from sclk falling edges
  logic [7:0] txb [0:127];
  int txn = 0;
  int fall_cnt = 0;
  int fall_base = 0;
  always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;
  always_comb begin
    int idx;
    idx = fall_cnt - fall_base;
    if (idx >= 0 && idx < txn * 8) sdi = txb[idx / 8][7 - (idx % 8)];
    else sdi = 1'b0;
  end

  // consumer: records deliveries, reads when allowed
  logic [7:0] got [0:255];
  logic [7:0] got_hdr [0:255];
  int gotn = 0;
  int got_base = 0;
  bit auto_read = 1'b1;
  bit man_req = 1'b0;
  always @(negedge clk) begin
    if ((auto_read || man_req) && rx_ready && !rst) begin
      got[gotn % 256]     <= rx_data;
      got_hdr[gotn % 256] <= header;
      gotn <= gotn + 1;
      rd_strobe <= 1'b1;
    end else begin
      rd_strobe <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    enable = 1'b0;
    @(negedge clk); rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] fbyte(input int f, input int osr, input int j);
    if (j == 2) return 8'hA5;
    return 8'((j * 13 + f * 50 + osr * 3 + 1) % 256);
  endfunction

  function automatic int flen(input int osr);
    return 6 * (osr + 1) + 2;
  endfunction

  task automatic push(input logic [7:0] b);
    txb[txn] = b;
    txn++;
  endtask

  task automatic start_stream();
    fall_base = fall_cnt;
    got_base = gotn;
    enable = 1'b1;
  endtask

  task automatic run_stream();
    wait_clk((txn + 2) * 8 * 2 * HD + 40);
    enable = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    int t0;
    int t1;
    int highs;
    // R10: reset state
    do_reset();
    chk(rx_ready == 1'b0, "R10 rx_ready", rx_ready, 0);
    chk(overrun == 1'b0, "R10 overrun", overrun, 0);
    chk(sclk_o == 1'b0, "R10 sclk_o", sclk_o, 0);
    chk(header == 8'h00, "R10 header", header, 0);
    chk(in_frame == 1'b0, "R10 in_frame", in_frame, 0);

    // R1: idle low while disabled
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk_o) highs++;
    end
    chk(highs == 0, "R1 idle sclk highs", highs, 0);

    // R1: period while enabled
    txn = 0;
    start_stream();
    @(posedge sclk_o); t0 = cyc;
    @(posedge sclk_o); t1 = cyc;
    chk((t1 - t0) == 2 * HD, "R1 sclk period", t1 - t0, 2 * HD);
    enable = 1'b0;
    wait_clk(2);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk_o) highs++;
    end
    chk(highs == 0, "R1 sclk after disable", highs, 0);

    // R2 R3 R4 R5 R7: two frames per oversampling code
    for (int osr = 0; osr < 4; osr++) begin
      int l;
      int exp_n;
      int bad;
      do_reset();
      osr_sel = 2'(osr);
      l = flen(osr);
      txn = 0;
      push(8'h3C); push(8'h5E); push(8'hA5);
      for (int j = 0; j < l; j++) push(fbyte(0, osr, j));
      push(8'h12); push(8'h77); push(8'hA5);
      for (int j = 0; j < l; j++) push(fbyte(1, osr, j));
      start_stream();
      run_stream();
      exp_n = 2 * (l + 1);
      chk((gotn - got_base) == exp_n, "R5 R7 delivered count", gotn - got_base, exp_n);
      chk(got[got_base % 256] == 8'hA5, "R3 first word is sync", got[got_base % 256], 8'hA5);
      chk(got_hdr[got_base % 256] == 8'h5E, "R4 first header", got_hdr[got_base % 256], 8'h5E);
      chk(got[(got_base + l + 1) % 256] == 8'hA5, "R7 second frame sync",
          got[(got_base + l + 1) % 256], 8'hA5);
      chk(header == 8'h77, "R4 second header", header, 8'h77);
      bad = 0;
      for (int j = 0; j < l; j++) begin
        if (got[(got_base + 1 + j) % 256] != fbyte(0, osr, j)) bad++;
        if (got[(got_base + l + 2 + j) % 256] != fbyte(1, osr, j)) bad++;
      end
      chk(bad == 0, "R2 R5 frame words mismatches", bad, 0);
      chk(overrun == 1'b0, "R8 no overrun with prompt reads", overrun, 0);
      chk(in_frame == 1'b0, "R7 hunting after frames", in_frame, 0);
    end

    // R6: rate code changed mid-frame
    do_reset();
    osr_sel = 2'd0;
    txn = 0;
    push(8'h01); push(8'hA5);
    for (int j = 0; j < flen(0); j++) push(fbyte(2, 0, j));
    start_stream();
    t0 = 0;
    while ((gotn - got_base) < 1 && t0 < 5000) begin @(negedge clk); t0++; end
    osr_sel = 2'd3;
    run_stream();
    chk((gotn - got_base) == flen(0) + 1, "R6 length latched at sync",
        gotn - got_base, flen(0) + 1);

    // R9 R8: no reads during a frame
    do_reset();
    osr_sel = 2'd0;
    auto_read = 1'b0;
    txn = 0;
    push(8'h5E); push(8'hA5);
    for (int j = 0; j < flen(0); j++) push(fbyte(3, 0, j));
    start_stream();
    run_stream();
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    chk(rx_ready == 1'b1, "R8 ready held", rx_ready, 1);
    chk(rx_data == fbyte(3, 0, flen(0) - 1), "R9 last word kept", rx_data,
        fbyte(3, 0, flen(0) - 1));
    man_req = 1'b1;
    wait_clk(3);
    man_req = 1'b0;
    wait_clk(2);
    chk(rx_ready == 1'b0, "R8 read clears ready", rx_ready, 0);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    auto_read = 1'b1;
    do_reset();
    chk(overrun == 1'b0, "R10 reset clears overrun", overrun, 0);
    chk(header == 8'h00, "R10 reset clears header", header, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule